// File: doc/BRIEF.md
# Companded PCM Code Formatter

This block sits between the serial PCM port of a voice codec and its conversion core. An 8-bit logarithmic sample is held internally as a sign bit, a 3-bit chord and a 4-bit step. On the bus the same sample travels in one of three line codes: plain sign-magnitude, sign with inverted magnitude, or alternate-digit inversion. In the encode direction the block turns an internal sample into its line code. In the decode direction it removes the line-code inversion and splits the result back into its fields.

In both directions it also returns the linear reconstruction magnitude of the sample for the selected companding law, µ-law or A-law. The magnitude is a scaled integer, doubled so that half steps are exact. One valid input gives one registered result a single clock later.

Top module: `pcm_code_fmt`

## Requirements
- R1: The internal sample layout is sign in bit 7, chord in bits 6:4 and step in bits 3:0. `out_sign`, `out_chord` and `out_step` report the fields of the internal sample.
- R2: Line-code select 0 (sign-magnitude) passes the code through unchanged in both directions.
- R3: Line-code select 1 (inverted magnitude) flips bits 6:0 and keeps bit 7, in both directions.
- R4: Line-code select 2 (alternate-digit inversion) flips bits 0, 2, 4 and 6 and keeps the other bits, in both directions.
- R5: Line-code select 3 behaves exactly like select 0.
- R6: With `dir`=0 (encode) the fields come from `in_code` itself. With `dir`=1 (decode) they come from `in_code` after the inversion is removed, which equals `out_code`.
- R7: With `law`=0 (µ-law) the magnitude is 2^C·(33+2S) − 33, which ranges from 0 to 8031.
- R8: With `law`=1 (A-law) the magnitude is 2^C·(33+2S) for C≠0, and 2+4S for C=0. The maximum is 8064.
- R9: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and the results appear in that same cycle.
- R10: While `in_valid` is low, `out_code`, the field outputs and `out_mag` keep their values.
- R11: While `rst_n` is low, `out_valid`, `out_code`, the field outputs and `out_mag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present this cycle |
| dir | input | 1 | 0 = encode internal to line, 1 = decode line to internal |
| law | input | 1 | 0 = µ-law, 1 = A-law |
| fmt | input | 2 | Line code: 0 plain, 1 inverted magnitude, 2 alternate digits, 3 as 0 |
| in_code | input | 8 | Internal sample (encode) or line code (decode) |
| out_valid | output | 1 | Result present this cycle |
| out_code | output | 8 | Line code (encode) or internal sample (decode) |
| out_sign | output | 1 | Sign of internal sample |
| out_chord | output | 3 | Chord of internal sample |
| out_step | output | 4 | Step of internal sample |
| out_mag | output | 14 | Doubled linear reconstruction magnitude |

## Verification
The assertions assume that `dir`, `law`, `fmt` and `in_code` carry known values whenever `in_valid` is high. They also assume that `in_valid` itself is never unknown once reset is released. The bench drives every input to a defined value from time zero and changes inputs only on falling edges. The hold checks deliberately present a different code and mode with `in_valid` low, to show that nothing moves.

// File: rtl/pcm_code_fmt.sv
module pcm_code_fmt #(
  parameter int CW = 8,
  parameter int MW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          dir,
  input  logic          law,
  input  logic [1:0]    fmt,
  input  logic [CW-1:0] in_code,
  output logic          out_valid,
  output logic [CW-1:0] out_code,
  output logic          out_sign,
  output logic [2:0]    out_chord,
  output logic [3:0]    out_step,
  output logic [MW-1:0] out_mag
);
  localparam logic [MW-1:0] BIAS = MW'(33);

  logic [CW-1:0] mask, flipped, fields;
  logic [2:0]    c;
  logic [3:0]    s;
  logic [MW-1:0] seg, mag;

  always_comb begin
    case (fmt)
      2'd1:    mask = 8'h7F;
      2'd2:    mask = 8'h55;
      default: mask = 8'h00;
    endcase
  end

  assign flipped = in_code ^ mask;
  assign fields  = dir ? flipped : in_code;
  assign c       = fields[6:4];
  assign s       = fields[3:0];
  assign seg     = (BIAS + MW'({s, 1'b0})) << c;

  always_comb begin
    if (!law)          mag = seg - BIAS;
    else if (c == 3'd0) mag = MW'(2) + MW'({s, 2'b00});
    else               mag = seg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= '0;
      out_sign  <= 1'b0;
      out_chord <= '0;
      out_step  <= '0;
      out_mag   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_code  <= flipped;
        out_sign  <= fields[7];
        out_chord <= c;
        out_step  <= s;
        out_mag   <= mag;
      end
    end
  end
endmodule

module pcm_code_fmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        dir,
  input logic        law,
  input logic [1:0]  fmt,
  input logic [7:0]  in_code,
  input logic        out_valid,
  input logic [7:0]  out_code,
  input logic        out_sign,
  input logic [2:0]  out_chord,
  input logic [3:0]  out_step,
  input logic [13:0] out_mag
);
  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_code) && $stable(out_mag) && $stable(out_chord));
  assert_plain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && fmt == 2'd0 |=> out_code == $past(in_code));
  assert_alt_digit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && fmt == 2'd2 |=> (out_code ^ $past(in_code)) == 8'h55);
  assert_encode_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !dir |=> {out_sign, out_chord, out_step} == $past(in_code));
  assert_decode_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && dir |=> {out_sign, out_chord, out_step} == out_code);
  assert_alaw_chord0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && law && !dir && in_code[6:4] == 3'd0 |=> out_mag[1:0] == 2'b10);
  assert_mag_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_mag <= 14'd8064);
endmodule

bind pcm_code_fmt pcm_code_fmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dir(dir), .law(law),
  .fmt(fmt), .in_code(in_code), .out_valid(out_valid), .out_code(out_code),
  .out_sign(out_sign), .out_chord(out_chord), .out_step(out_step),
  .out_mag(out_mag)
);

// File: tb/tb_pcm_code_fmt.sv
`timescale 1ns/1ps
module tb_pcm_code_fmt;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, dir = 1'b0, law = 1'b0;
  logic [1:0] fmt = 2'd0;
  logic [7:0] in_code = 8'h00;
  logic out_valid, out_sign;
  logic [7:0] out_code;
  logic [2:0] out_chord;
  logic [3:0] out_step;
  logic [13:0] out_mag;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pcm_code_fmt dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dir(dir), .law(law),
    .fmt(fmt), .in_code(in_code), .out_valid(out_valid), .out_code(out_code),
    .out_sign(out_sign), .out_chord(out_chord), .out_step(out_step),
    .out_mag(out_mag)
  );

  // {dir, law, fmt, in_code, expected out_code, expected out_mag}
  localparam int NV = 12;
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 1'b0, 2'd0, 8'h00, 8'h00, 14'd0},     // R2 R7
    {1'b0, 1'b0, 2'd1, 8'h80, 8'hFF, 14'd0},     // R3 R7
    {1'b0, 1'b0, 2'd2, 8'h7F, 8'h2A, 14'd8031},  // R4 R7
    {1'b0, 1'b1, 2'd2, 8'h00, 8'h55, 14'd2},     // R4 R8
    {1'b1, 1'b1, 2'd2, 8'hD5, 8'h80, 14'd2},     // R4 R6 R8
    {1'b1, 1'b0, 2'd1, 8'h6F, 8'h10, 14'd33},    // R3 R6 R7
    {1'b1, 1'b1, 2'd0, 8'h9A, 8'h9A, 14'd106},   // R2 R8
    {1'b0, 1'b1, 2'd3, 8'h3C, 8'h3C, 14'd456},   // R5 R8
    {1'b1, 1'b0, 2'd3, 8'hA5, 8'hA5, 14'd139},   // R5 R7
    {1'b0, 1'b1, 2'd1, 8'h0F, 8'h70, 14'd62},    // R3 R8
    {1'b1, 1'b1, 2'd1, 8'h70, 8'h0F, 14'd62},    // R3 R6 R8
    {1'b0, 1'b1, 2'd0, 8'hFF, 8'hFF, 14'd8064}   // R2 R8
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 valid", 32'(out_valid), 0);
    chk("R11 code", 32'(out_code), 0);
    chk("R11 mag", 32'(out_mag), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [7:0] expf;
      @(negedge clk);
      {dir, law, fmt, in_code} = VEC[i][33:22];
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      expf = VEC[i][33] ? VEC[i][21:14] : VEC[i][29:22];
      chk("R9 valid", 32'(out_valid), 1);
      chk("R2-5 code", 32'(out_code), 32'(VEC[i][21:14]));
      chk("R1 R6 fields", 32'({out_sign, out_chord, out_step}), 32'(expf));
      chk("R7/R8 mag", 32'(out_mag), 32'(VEC[i][13:0]));
    end

    // R9: valid drops the cycle after an idle input; R10: outputs hold
    @(negedge clk);
    chk("R9 drop", 32'(out_valid), 0);
    dir = 1'b1; law = 1'b0; fmt = 2'd1; in_code = 8'h33;
    repeat (2) @(negedge clk);
    chk("R10 code", 32'(out_code), 32'h0FF);
    chk("R10 mag", 32'(out_mag), 8064);
    chk("R10 chord", 32'(out_chord), 7);

    // R9: back-to-back valids give back-to-back results
    dir = 1'b0; law = 1'b0; fmt = 2'd0; in_code = 8'h10; in_valid = 1'b1;
    @(negedge clk);
    chk("R9 b2b first", 32'(out_mag), 33);
    in_code = 8'h20;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 b2b valid", 32'(out_valid), 1);
    chk("R7 b2b second", 32'(out_mag), 99);

    // R11: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 re-reset valid", 32'(out_valid), 0);
    chk("R11 re-reset mag", 32'(out_mag), 0);
    chk("R11 re-reset fields", 32'({out_sign, out_chord, out_step}), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule